// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Ready-to-Receive Handshake

This block takes in 8-bit words from a partner over a clocked serial link made of one data line and one transfer clock. The host arms the receiver by issuing a dummy transmit write while both enables are set. The receiver then pulls an active-low ready-to-receive line (`rts_n`) low, which tells the partner it may start supplying the transfer clock. Bits are shifted in on the chosen clock edge. When eight bits have arrived, the word moves into a receive buffer, a completion flag is raised and a one-cycle interrupt request is pulsed.

The transfer clock comes from one of two sources. It can be generated inside the block from the system clock at one of three divide ratios, and it is then driven out on `sclk_out`. It can also be taken from an external pin, in which case both the clock and the data line pass through a two-flop synchronizer and clock edges are found in the system clock domain. Three options apply to every word: sampling on the falling edge instead of the rising edge, sending the first-received bit to the top of the word, and inverting each bit as it is stored. A continuous mode re-arms the receiver whenever the host reads the buffer, so no new dummy write is needed. Without it, the receiver stays idle after each word until the next dummy write.

Top module: `sync_ser_rx`

## Requirements
- R1: The receiver becomes ready only on a `tx_wr` pulse seen while `cfg_rx_en`=1 and `cfg_tx_en`=1. While it is not ready, `tx_wr` with `cfg_tx_en`=0 has no effect and transfer-clock edges store nothing: `rts_n` stays 1 and `rx_done` and `rx_data` do not change.
- R2: `rts_n` is registered. It is 0 in the clock edge where the receiver becomes ready, provided `cfg_rts_en`=1, and it is 1 whenever the receiver is not ready. When `cfg_rts_en`=0, `rts_n` stays 1 but reception still works.
- R3: In the default order (`cfg_msb_first`=0), each sampled bit enters the top bit of the shift register and the contents move one place toward bit 0. After eight samples, the first bit received sits in `rx_data[0]`.
- R4: On the eighth sample edge, the word is copied to `rx_data`, `rx_done` becomes 1 and `rx_irq` is 1 for exactly one cycle. All three change in the same clock edge.
- R5: The internal clock is selected by `cfg_clk_src`: 0 divides by 1, 1 divides by 8 and 2 divides by 32. `sclk_out` idles at 1. For each armed word it makes eight low pulses, each half period lasting the divide ratio in system clocks, and it ends at 1.
- R6: A `rd_lo` pulse clears `rx_done` at the next edge. If a word completes in the same cycle, the completion wins and `rx_done` stays 1.
- R7: With `cfg_fall_edge`=1, bits are sampled on falling edges of the transfer clock instead of rising edges.
- R8: With `cfg_msb_first`=1, each bit enters bit 0 and the contents move toward the top, so the first bit received ends in `rx_data[7]`.
- R9: With `cfg_invert`=1, every sampled bit is inverted before it is stored.
- R10: When a word completes, the receiver leaves the ready state and `rts_n` goes to 1. With `cfg_cont`=0 it stays there until the next dummy write, and a read does not change it. With `cfg_cont`=1, a `rd_lo` pulse (with both enables at 1) makes it ready again at the next edge.
- R11: If a word completes while `rx_done` is still 1 and no read arrives in that cycle, `rx_ovr` becomes 1 and `rx_data` is overwritten with the new word. `rx_ovr` clears on `rd_lo`.
- R12: With `cfg_clk_src`=3, the external clock and data pass through two synchronizer flops. A sampling edge that reaches `sclk_in` before clock edge k takes effect in edge k+2, using the data value present before edge k.
- R13: Dropping `cfg_rx_en` to 0 clears the ready state, stops the internal clock at 1 and discards any partly received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_tx_en | input | 1 | Transmit enable, required for arming |
| cfg_rts_en | input | 1 | 1 drives the ready-to-receive handshake, 0 holds `rts_n` at 1 |
| cfg_clk_src | input | 2 | 0/1/2: internal clock divided by 1/8/32; 3: external clock |
| cfg_fall_edge | input | 1 | 1 samples on falling edges |
| cfg_msb_first | input | 1 | 1 places the first bit received at bit 7 |
| cfg_invert | input | 1 | 1 inverts received bits |
| cfg_cont | input | 1 | 1 re-arms on a buffer read |
| tx_wr | input | 1 | Dummy transmit write strobe, one cycle |
| rd_lo | input | 1 | Host read of the buffer low byte, one cycle |
| sclk_in | input | 1 | External transfer clock |
| sdata_in | input | 1 | Serial data |
| sclk_out | output | 1 | Internally generated transfer clock |
| rts_n | output | 1 | Ready-to-receive, active low |
| rx_data | output | 8 | Receive buffer |
| rx_done | output | 1 | Receive-complete flag |
| rx_irq | output | 1 | Receive interrupt request, one-cycle pulse |
| rx_ovr | output | 1 | Overrun flag |

## Verification
Every output is registered. Arming, reads and enable changes show up one edge after the strobe is sampled. An external sampling edge reaches the flags and the buffer two edges after it appears on `sclk_in`, and an internal sampling edge acts in the same edge in which `sclk_out` toggles. The bench snapshots every input at each rising edge and steps a behavioural model with that snapshot. It keeps the last three sampled values of the external clock and data, so the two-cycle synchronizer delay is applied in the model itself, and it compares all outputs a few nanoseconds after the same edge. Directed checks read the outputs at a fixed offset after the edge on which each effect is due, and R12 is checked at the cycle before and the cycle of the completion.

// File: rtl/srx_pkg.sv
package srx_pkg;

  // transfer clock source, encoded as on cfg_clk_src
  typedef enum logic [1:0] {
    SRC_DIV_A = 2'd0,
    SRC_DIV_B = 2'd1,
    SRC_DIV_C = 2'd2,
    SRC_EXT   = 2'd3
  } clk_src_e;

endpackage

// File: rtl/srx_rst_sync.sv
module srx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];

endmodule

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_n[g] = d_i;
      end else begin : g_rest
        assign chain_n[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_n;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/srx_clkgen.sv
module srx_clkgen
  import srx_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_A = 1,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     abort_i,
  input  clk_src_e sel_i,
  output logic     sclk_o,
  output logic     rise_o,
  output logic     fall_o
);

  localparam int DMAX = (DIV_A > DIV_B) ? ((DIV_A > DIV_C) ? DIV_A : DIV_C)
                                        : ((DIV_B > DIV_C) ? DIV_B : DIV_C);
  localparam int DCW  = $clog2(DMAX + 1);
  localparam int NTOG = 2 * W;
  localparam int TW   = $clog2(NTOG);

  logic           run_q, run_n;
  logic           sclk_q, sclk_n;
  logic [DCW-1:0] div_q, div_n;
  logic [TW-1:0]  tog_q, tog_n;
  logic [DCW-1:0] lim_m1;
  logic           tick;
  logic           tick_eff;

  always_comb begin
    case (sel_i)
      SRC_DIV_A: lim_m1 = DCW'(DIV_A - 1);
      SRC_DIV_B: lim_m1 = DCW'(DIV_B - 1);
      SRC_DIV_C: lim_m1 = DCW'(DIV_C - 1);
      default:   lim_m1 = DCW'(DIV_A - 1);
    endcase
  end

  assign tick     = run_q && (div_q == lim_m1);
  assign tick_eff = tick && !abort_i && !start_i;

  always_comb begin
    run_n  = run_q;
    sclk_n = sclk_q;
    div_n  = div_q;
    tog_n  = tog_q;
    if (abort_i) begin
      run_n  = 1'b0;
      sclk_n = 1'b1;
      div_n  = '0;
      tog_n  = '0;
    end else if (start_i) begin
      run_n  = 1'b1;
      sclk_n = 1'b1;
      div_n  = '0;
      tog_n  = '0;
    end else if (run_q) begin
      if (tick) begin
        div_n  = '0;
        sclk_n = ~sclk_q;
        tog_n  = tog_q + 1'b1;
        if (tog_q == TW'(NTOG - 1)) run_n = 1'b0;
      end else begin
        div_n = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sclk_q <= 1'b1;
      div_q  <= '0;
      tog_q  <= '0;
    end else begin
      run_q  <= run_n;
      sclk_q <= sclk_n;
      div_q  <= div_n;
      tog_q  <= tog_n;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = tick_eff && !sclk_q;
  assign fall_o = tick_eff &&  sclk_q;

  // R5: a stopped generator always rests at the high level
  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> sclk_q);

  // R13: abort leaves the clock high and stopped
  p_abort_stops_r13: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!run_q && sclk_q));

endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         evt_i,
  input  logic         bit_i,
  input  logic         msb_first_i,
  input  logic         invert_i,
  output logic         last_o,
  output logic [W-1:0] word_o
);

  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q, sh_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          b;
  logic          take;
  logic [W-1:0]  shifted;

  assign b       = bit_i ^ invert_i;
  assign take    = evt_i && !clear_i;
  assign shifted = msb_first_i ? {sh_q[W-2:0], b} : {b, sh_q[W-1:1]};
  assign last_o  = take && (cnt_q == CW'(W - 1));
  assign word_o  = shifted;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (clear_i) begin
      cnt_n = '0;
    end else if (take) begin
      sh_n  = shifted;
      cnt_n = last_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  // R4: a completed word restarts the bit count
  p_count_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (cnt_q == '0));

  // R13: disabling discards a partial word
  p_clear_discards_r13: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/sync_ser_rx.sv
module sync_ser_rx
  import srx_pkg::*;
#(
  parameter int W           = 8,
  parameter int DIV_A       = 1,
  parameter int DIV_B       = 8,
  parameter int DIV_C       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         cfg_rx_en,
  input  logic         cfg_tx_en,
  input  logic         cfg_rts_en,
  input  logic [1:0]   cfg_clk_src,
  input  logic         cfg_fall_edge,
  input  logic         cfg_msb_first,
  input  logic         cfg_invert,
  input  logic         cfg_cont,
  input  logic         tx_wr,
  input  logic         rd_lo,
  input  logic         sclk_in,
  input  logic         sdata_in,
  output logic         sclk_out,
  output logic         rts_n,
  output logic [W-1:0] rx_data,
  output logic         rx_done,
  output logic         rx_irq,
  output logic         rx_ovr
);

  logic         rst_n;
  clk_src_e     src;
  logic         use_ext;
  logic         sclk_s, sdata_s;
  logic         ext_prev_q;
  logic         ext_rise, ext_fall;
  logic         gen_rise, gen_fall;
  logic         smp_rise, smp_fall;
  logic         evt;
  logic         last;
  logic [W-1:0] word;
  logic         arm_req, rearm_req;
  logic         ready_q, ready_n;
  logic         gen_start;
  logic         done_q, done_n;
  logic         ovr_q, ovr_n;
  logic         irq_q;
  logic         rts_q;
  logic [W-1:0] buf_q, buf_n;

  assign src     = clk_src_e'(cfg_clk_src);
  assign use_ext = (src == SRC_EXT);

  srx_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sclk_in),
    .q_o   (sclk_s)
  );

  srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sdata_in),
    .q_o   (sdata_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev_q <= 1'b1;
    else        ext_prev_q <= sclk_s;
  end

  assign ext_rise =  sclk_s && !ext_prev_q;
  assign ext_fall = !sclk_s &&  ext_prev_q;

  // arming and handshake state
  assign arm_req   = tx_wr && cfg_rx_en && cfg_tx_en;
  assign rearm_req = cfg_cont && rd_lo && cfg_rx_en && cfg_tx_en;

  always_comb begin
    ready_n = ready_q;
    if (!cfg_rx_en)                 ready_n = 1'b0;
    else if (last)                  ready_n = 1'b0;
    else if (arm_req || rearm_req)  ready_n = 1'b1;
  end

  assign gen_start = ready_n && !ready_q && !use_ext;

  srx_clkgen #(.W(W), .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (gen_start),
    .abort_i (!cfg_rx_en),
    .sel_i   (src),
    .sclk_o  (sclk_out),
    .rise_o  (gen_rise),
    .fall_o  (gen_fall)
  );

  assign smp_rise = use_ext ? ext_rise : gen_rise;
  assign smp_fall = use_ext ? ext_fall : gen_fall;
  assign evt      = ready_q && (cfg_fall_edge ? smp_fall : smp_rise);

  srx_shift #(.W(W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (!cfg_rx_en),
    .evt_i       (evt),
    .bit_i       (sdata_s),
    .msb_first_i (cfg_msb_first),
    .invert_i    (cfg_invert),
    .last_o      (last),
    .word_o      (word)
  );

  // buffer and flags
  always_comb begin
    buf_n  = buf_q;
    done_n = done_q;
    ovr_n  = ovr_q;
    if (last) begin
      buf_n  = word;
      done_n = 1'b1;
      ovr_n  = (ovr_q || done_q) && !rd_lo;
    end else if (rd_lo) begin
      done_n = 1'b0;
      ovr_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
      irq_q   <= 1'b0;
      rts_q   <= 1'b1;
      buf_q   <= '0;
    end else begin
      ready_q <= ready_n;
      done_q  <= done_n;
      ovr_q   <= ovr_n;
      irq_q   <= last;
      rts_q   <= !(cfg_rts_en && ready_n);
      buf_q   <= buf_n;
    end
  end

  assign rts_n   = rts_q;
  assign rx_data = buf_q;
  assign rx_done = done_q;
  assign rx_irq  = irq_q;
  assign rx_ovr  = ovr_q;

  // R2: handshake never shows ready while idle
  p_rts_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_q |-> rts_q);

  // R1: ready only follows a qualifying dummy write or continuous re-arm
  p_ready_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> ($past(tx_wr && cfg_rx_en && cfg_tx_en) ||
                        $past(cfg_cont && rd_lo && cfg_rx_en && cfg_tx_en)));

  // R4: interrupt request is a single-cycle pulse
  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R4: interrupt request and complete flag rise together
  p_irq_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> done_q);

  // R6: a read without a coinciding completion clears the flag
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !last) |=> !done_q);

  // R11: overrun only arises over an unread word
  p_ovr_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(done_q));

endmodule

// File: tb/sync_ser_rx_tb_top.sv
`timescale 1ns/1ps
module sync_ser_rx_tb_top;

  logic       clk;
  logic       arst_n;
  logic       cfg_rx_en, cfg_tx_en, cfg_rts_en;
  logic [1:0] cfg_clk_src;
  logic       cfg_fall_edge, cfg_msb_first, cfg_invert, cfg_cont;
  logic       tx_wr, rd_lo, sclk_in, sdata_in;
  logic       sclk_out, rts_n, rx_done, rx_irq, rx_ovr;
  logic [7:0] rx_data;

  int nvec  = 0;
  int nfail = 0;
  int cyc   = 0;
  bit model_on = 0;

  sync_ser_rx dut_i (
    .clk(clk), .arst_n(arst_n),
    .cfg_rx_en(cfg_rx_en), .cfg_tx_en(cfg_tx_en), .cfg_rts_en(cfg_rts_en),
    .cfg_clk_src(cfg_clk_src), .cfg_fall_edge(cfg_fall_edge),
    .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert), .cfg_cont(cfg_cont),
    .tx_wr(tx_wr), .rd_lo(rd_lo), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sclk_out(sclk_out), .rts_n(rts_n), .rx_data(rx_data),
    .rx_done(rx_done), .rx_irq(rx_irq), .rx_ovr(rx_ovr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic       m_ready, m_done, m_ovr, m_irq, m_rts;
  logic [7:0] m_sh, m_buf;
  int         m_cnt;
  logic       c1, c2, c3, d1, d2;

  always @(posedge clk) begin
    if (model_on) begin
      logic s_tx, s_rd, s_rxen, s_txen, s_rtsen, s_fall, s_msb, s_inv, s_cont;
      logic s_sc, s_sd, s_oldso, newso, rise, fall, bitv, evt, last, b;
      logic [1:0] s_src;
      s_tx = tx_wr; s_rd = rd_lo; s_rxen = cfg_rx_en; s_txen = cfg_tx_en;
      s_rtsen = cfg_rts_en; s_fall = cfg_fall_edge; s_msb = cfg_msb_first;
      s_inv = cfg_invert; s_cont = cfg_cont; s_src = cfg_clk_src;
      s_sc = sclk_in; s_sd = sdata_in; s_oldso = sclk_out;
      #5;
      newso = sclk_out;
      if (s_src == 2'd3) begin
        rise = c2 && !c3;
        fall = !c2 && c3;
      end else begin
        rise = !s_oldso && newso;
        fall = s_oldso && !newso;
      end
      bitv = d2;
      c3 = c2; c2 = c1; c1 = s_sc;
      d2 = d1; d1 = s_sd;
      evt  = m_ready && (s_fall ? fall : rise);
      last = 1'b0;
      if (!s_rxen) begin
        m_cnt = 0;
      end else if (evt) begin
        b = bitv ^ s_inv;
        m_sh = s_msb ? {m_sh[6:0], b} : {b, m_sh[7:1]};
        if (m_cnt == 7) begin last = 1'b1; m_cnt = 0; end
        else m_cnt++;
      end
      if (last) begin
        m_ovr  = (m_ovr || m_done) && !s_rd;
        m_done = 1'b1;
        m_buf  = m_sh;
      end else if (s_rd) begin
        m_done = 1'b0;
        m_ovr  = 1'b0;
      end
      if (!s_rxen) m_ready = 1'b0;
      else if (last) m_ready = 1'b0;
      else if ((s_tx && s_txen) || (s_cont && s_rd && s_txen)) m_ready = 1'b1;
      m_rts = !(s_rtsen && m_ready);
      m_irq = last;
      chk("R2 model rts_n", rts_n, m_rts);
      chk("R4 model rx_done", rx_done, m_done);
      chk("R4 model rx_irq", rx_irq, m_irq);
      chk("R11 model rx_ovr", rx_ovr, m_ovr);
      chk("R3 model rx_data", rx_data, m_buf);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic arm();
    tx_wr = 1'b1; tick(1); tx_wr = 1'b0;
  endtask

  task automatic rd();
    rd_lo = 1'b1; tick(1); rd_lo = 1'b0;
  endtask

  task automatic send_ext(input logic [7:0] v, input bit msb, input int nbits, input bit lat);
    for (int i = 0; i < nbits; i++) begin
      sdata_in = msb ? v[7-i] : v[i];
      tick(4); sclk_in = 1'b0;
      tick(4); sclk_in = 1'b1;
      if (lat && i == nbits - 1) begin
        tick(2); chk("R12 not yet complete", rx_done, 1'b0);
        tick(1); chk("R12 complete two edges later", rx_done, 1'b1);
        tick(1);
      end else begin
        tick(4);
      end
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (rx_done !== 1'b1 && n < 3000) begin tick(1); n++; end
    chk(tag, rx_done, 1'b1);
  endtask

  task automatic send_int(input logic [7:0] v, input int half);
    int falls = 0;
    int tfall = 0;
    int guard = 0;
    logic p = sclk_out;
    while (falls < 8 && guard < 3000) begin
      @(posedge clk); #4;
      guard++;
      if (p && !sclk_out) begin
        sdata_in = v[falls];
        if (falls == 0) tfall = cyc;
        falls++;
      end else if (!p && sclk_out && falls == 1) begin
        chk("R5 half period", cyc - tfall, half);
      end
      p = sclk_out;
    end
    wait_done("R5 internal word completes");
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  // ---------------- test sequence ----------------
  initial begin
    arst_n = 1'b0;
    cfg_rx_en = 1'b1; cfg_tx_en = 1'b0; cfg_rts_en = 1'b1;
    cfg_clk_src = 2'd3; cfg_fall_edge = 1'b0; cfg_msb_first = 1'b0;
    cfg_invert = 1'b0; cfg_cont = 1'b0;
    tx_wr = 1'b0; rd_lo = 1'b0; sclk_in = 1'b1; sdata_in = 1'b0;
    m_ready = 0; m_done = 0; m_ovr = 0; m_irq = 0; m_rts = 1;
    m_sh = 8'h00; m_buf = 8'h00; m_cnt = 0;
    c1 = 1; c2 = 1; c3 = 1; d1 = 0; d2 = 0;
    tick(5);
    arst_n = 1'b1;
    tick(6);
    model_on = 1;

    // reset state
    chk("R2 reset rts_n", rts_n, 1'b1);
    chk("R4 reset rx_done", rx_done, 1'b0);
    chk("R4 reset rx_irq", rx_irq, 1'b0);
    chk("R11 reset rx_ovr", rx_ovr, 1'b0);
    chk("R5 reset sclk_out", sclk_out, 1'b1);
    chk("R3 reset rx_data", rx_data, 8'h00);

    // R1: dummy write with transmit disabled does not arm
    arm();
    chk("R1 no arm without tx enable", rts_n, 1'b1);
    send_ext(8'hA5, 0, 8, 0);
    chk("R1 unarmed edges store nothing", rx_done, 1'b0);
    chk("R1 unarmed buffer unchanged", rx_data, 8'h00);

    // R2/R3/R4/R12/R10/R6: plain reception
    cfg_tx_en = 1'b1;
    arm();
    chk("R2 rts_n low after arm", rts_n, 1'b0);
    send_ext(8'h3C, 0, 8, 1);
    chk("R3 lsb-first word", rx_data, 8'h3C);
    chk("R4 done set", rx_done, 1'b1);
    chk("R10 rts_n high after word", rts_n, 1'b1);
    rd();
    chk("R6 read clears done", rx_done, 1'b0);
    chk("R10 no re-arm on read when not continuous", rts_n, 1'b1);

    // R7 falling edge
    cfg_fall_edge = 1'b1;
    arm(); send_ext(8'h5B, 0, 8, 0);
    chk("R7 falling-edge word", rx_data, 8'h5B);
    rd(); cfg_fall_edge = 1'b0;

    // R8 msb first
    cfg_msb_first = 1'b1;
    arm(); send_ext(8'h96, 1, 8, 0);
    chk("R8 msb-first word", rx_data, 8'h96);
    rd(); cfg_msb_first = 1'b0;

    // R9 inversion
    cfg_invert = 1'b1;
    arm(); send_ext(8'h0F, 0, 8, 0);
    chk("R9 inverted word", rx_data, 8'hF0);
    rd(); cfg_invert = 1'b0;

    // R11 overrun
    arm(); send_ext(8'h11, 0, 8, 0);
    arm(); send_ext(8'h22, 0, 8, 0);
    chk("R11 overrun set", rx_ovr, 1'b1);
    chk("R11 buffer overwritten", rx_data, 8'h22);
    rd();
    chk("R11 overrun cleared by read", rx_ovr, 1'b0);

    // R2 handshake disabled
    cfg_rts_en = 1'b0;
    arm();
    chk("R2 rts_n held high when disabled", rts_n, 1'b1);
    send_ext(8'h5A, 0, 8, 0);
    chk("R2 reception without handshake", rx_data, 8'h5A);
    rd(); cfg_rts_en = 1'b1;

    // R10 continuous mode
    cfg_cont = 1'b1;
    arm(); send_ext(8'h81, 0, 8, 0);
    chk("R10 rts_n high after word", rts_n, 1'b1);
    chk("R10 first continuous word", rx_data, 8'h81);
    rd();
    chk("R10 read re-arms", rts_n, 1'b0);
    send_ext(8'h7E, 0, 8, 0);
    chk("R10 second word without dummy write", rx_data, 8'h7E);
    rd();
    cfg_cont = 1'b0;

    // R13 disable discards partial word
    send_ext(8'hFF, 0, 4, 0);
    cfg_rx_en = 1'b0; tick(1); cfg_rx_en = 1'b1;
    chk("R13 disable drops ready", rts_n, 1'b1);
    chk("R13 no completion from partial", rx_done, 1'b0);
    arm(); send_ext(8'hC3, 0, 8, 0);
    chk("R13 fresh word after disable", rx_data, 8'hC3);
    rd();

    // R5 internal clock, divide by 8
    cfg_clk_src = 2'd1;
    tick(2);
    arm(); send_int(8'hB4, 8);
    chk("R5 div8 word", rx_data, 8'hB4);
    tick(2);
    chk("R5 clock idles high after word", sclk_out, 1'b1);
    rd();

    // R5 divide by 32
    cfg_clk_src = 2'd2;
    tick(2);
    arm(); send_int(8'h4B, 32);
    chk("R5 div32 word", rx_data, 8'h4B);
    rd();

    // R5 divide by 1 with constant data
    cfg_clk_src = 2'd0;
    sdata_in = 1'b1;
    tick(3);
    arm();
    wait_done("R5 div1 word completes");
    chk("R5 div1 constant word", rx_data, 8'hFF);
    tick(2);
    chk("R5 div1 clock idles high", sclk_out, 1'b1);
    rd();
    sdata_in = 1'b0;
    cfg_clk_src = 2'd3;
    tick(4);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule